// File: doc/BRIEF.md
# Bit-plane maximum/minimum selector

This unit picks the largest or the smallest of several unsigned operands, and it uses no magnitude comparator to do so. The operands are viewed as bit planes. Plane k is the vector that holds bit k of every operand. The unit walks the planes from the most significant bit down to bit 0. A candidate vector has one bit per operand and marks the operands that can still win. When an operand loses at some bit position, its candidate bit is dropped. Each result bit is a single reduction over the current plane under the candidate vector, so the logic per bit is a narrow AND/OR layer and not a comparator chain.

A mode input selects maximum or minimum for each sample. An optional pipeline register can be placed after every `PIPE_EVERY` bit stages to trade latency for clock rate. The output is always registered. Operands are presented as one packed bus with a valid strobe, and a new set may enter on every clock. The default build has five operands of eight bits, which is the width of the basic sorting element in a morphological window engine.

Top module: `bitplane_minmax`

## Requirements
- R1: With `sel_max`=1 the result equals the largest of the `N_OPS` operands, as unsigned numbers.
- R2: With `sel_max`=0 the result equals the smallest of the operands, as unsigned numbers.
- R3: For the operands 25, 237, 59, 179 and 48 the result is 237 in maximum mode and 25 in minimum mode.
- R4: Equal operands do not disturb the selection. When several operands share the winning value, that value is returned. When all operands are equal, their common value is returned in both modes.
- R5: Every valid result is bit-for-bit equal to one of the operands of its own sample.
- R6: When all operands are 0 the result is 0 in both modes. When all operands are all-ones (255 by default) the result is all-ones in both modes.
- R7: `out_valid` is high exactly LAT cycles after `in_valid` was sampled high, with LAT = 1 + (WIDTH-1)/PIPE_EVERY, or 1 when PIPE_EVERY is 0 (4 by default). Back-to-back samples, with the mode changing on each one, come out in order.
- R8: `out_result` changes only on a cycle in which `out_valid` is high, and otherwise holds its last value.
- R9: While `rst` is high, and in the cycle after it falls, `out_valid` is 0 and `out_result` is 0.
- R10: Operand i occupies bits [i*WIDTH +: WIDTH] of `operands`, and every position takes part equally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a sample on `operands` |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| operands | input | N_OPS*WIDTH | Packed operands, operand i at bits [i*WIDTH +: WIDTH] |
| out_valid | output | 1 | Result strobe, LAT cycles after the sample |
| out_result | output | WIDTH | Selected operand value |

## Verification
A wrong candidate vector, for example one that keeps a loser or drops the only winner, shows up at the ports as a result that matches no operand, or as one that is beaten by another operand. This appears in the output strobe of the same sample, LAT cycles after entry. A misplaced pipeline stage shows up as a strobe one cycle early or late. A mode that does not travel with its sample gives wrong values when the mode alternates sample by sample. Dense streams with many ties and values of all zeros or all ones expose flags that are updated on the wrong polarity.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  typedef enum logic {
    SEL_MIN = 1'b0,
    SEL_MAX = 1'b1
  } sel_e;
endpackage

// File: rtl/mmx_plane_pick.sv
// Gathers bit BIT of every packed operand into one plane vector.
module mmx_plane_pick #(
  parameter int N_OPS = 5,
  parameter int WIDTH = 8,
  parameter int BIT   = 0
) (
  input  logic [N_OPS*WIDTH-1:0] ops,
  output logic [N_OPS-1:0]       plane
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign plane[i] = ops[i*WIDTH + BIT];
  end
endmodule

// File: rtl/mmx_bit_stage.sv
// One bit position: a reduction under the candidate vector, then the candidate update.
module mmx_bit_stage
  import mmx_pkg::*;
#(
  parameter int N_OPS = 5
) (
  input  logic [N_OPS-1:0] plane,
  input  logic [N_OPS-1:0] flag_in,
  input  sel_e             sel,
  output logic             bit_o,
  output logic [N_OPS-1:0] flag_o
);
  logic [N_OPS-1:0] merged;

  always_comb begin
    if (sel == SEL_MAX) begin
      // Survivors have a 1 here; if any survivor does, the losers drop out.
      merged = plane & flag_in;
      bit_o  = |merged;
      flag_o = bit_o ? merged : flag_in;
    end else begin
      // Candidate bit 0 means still in play; a 0 in the plane keeps it in play.
      merged = plane | flag_in;
      bit_o  = &merged;
      flag_o = bit_o ? flag_in : merged;
    end
  end
endmodule

// File: rtl/mmx_pipe_reg.sv
module mmx_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/bitplane_minmax.sv
module bitplane_minmax
  import mmx_pkg::*;
#(
  parameter int N_OPS      = 5,
  parameter int WIDTH      = 8,
  parameter int PIPE_EVERY = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   sel_max,
  input  logic [N_OPS*WIDTH-1:0] operands,
  output logic                   out_valid,
  output logic [WIDTH-1:0]       out_result
);
  localparam int OPW     = N_OPS * WIDTH;
  localparam int EV      = (PIPE_EVERY > 0) ? PIPE_EVERY : 1;
  localparam int BUNDLE  = OPW + N_OPS + WIDTH + 2;

  // State at each boundary between bit stages; index s has s bits resolved.
  logic [OPW-1:0]   ops_s  [0:WIDTH];
  logic [N_OPS-1:0] flag_s [0:WIDTH];
  logic [WIDTH-1:0] res_s  [0:WIDTH];
  sel_e             mode_s [0:WIDTH];
  logic             vld_s  [0:WIDTH];

  assign ops_s[0]  = operands;
  assign mode_s[0] = sel_e'(sel_max);
  assign flag_s[0] = sel_max ? {N_OPS{1'b1}} : {N_OPS{1'b0}};
  assign res_s[0]  = '0;
  assign vld_s[0]  = in_valid;

  for (genvar s = 0; s < WIDTH; s++) begin : g_stage
    localparam int BITPOS = WIDTH - 1 - s;
    logic [N_OPS-1:0] plane;
    logic             bit_c;
    logic [N_OPS-1:0] flag_c;
    logic [WIDTH-1:0] res_c;

    mmx_plane_pick #(.N_OPS(N_OPS), .WIDTH(WIDTH), .BIT(BITPOS)) u_pick (
      .ops   (ops_s[s]),
      .plane (plane)
    );

    mmx_bit_stage #(.N_OPS(N_OPS)) u_bit (
      .plane   (plane),
      .flag_in (flag_s[s]),
      .sel     (mode_s[s]),
      .bit_o   (bit_c),
      .flag_o  (flag_c)
    );

    always_comb begin
      res_c         = res_s[s];
      res_c[BITPOS] = bit_c;
    end

    if ((PIPE_EVERY > 0) && (((s + 1) % EV) == 0) && ((s + 1) < WIDTH)) begin : g_reg
      logic [BUNDLE-1:0] d_b;
      logic [BUNDLE-1:0] q_b;
      assign d_b = {ops_s[s], flag_c, res_c, mode_s[s], vld_s[s]};
      mmx_pipe_reg #(.W(BUNDLE)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (d_b),
        .q   (q_b)
      );
      assign ops_s[s+1]  = q_b[BUNDLE-1 -: OPW];
      assign flag_s[s+1] = q_b[WIDTH+2 +: N_OPS];
      assign res_s[s+1]  = q_b[2 +: WIDTH];
      assign mode_s[s+1] = sel_e'(q_b[1]);
      assign vld_s[s+1]  = q_b[0];
    end else begin : g_wire
      assign ops_s[s+1]  = ops_s[s];
      assign flag_s[s+1] = flag_c;
      assign res_s[s+1]  = res_c;
      assign mode_s[s+1] = mode_s[s];
      assign vld_s[s+1]  = vld_s[s];
    end

    // R1: in max mode the candidate set only shrinks and never empties
    a_r1_flag_narrows: assert property (@(posedge clk) disable iff (rst)
      (vld_s[s] && mode_s[s] == SEL_MAX) |->
        (((flag_c & ~flag_s[s]) == '0) && (flag_c != '0)));
    // R2: in min mode the eliminated set only grows and never covers all operands
    a_r2_flag_widens: assert property (@(posedge clk) disable iff (rst)
      (vld_s[s] && mode_s[s] == SEL_MIN) |->
        (((flag_s[s] & ~flag_c) == '0) && (~flag_c != '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= vld_s[WIDTH];
      if (vld_s[WIDTH]) out_result <= res_s[WIDTH];
    end
  end

  // Checks on the fully resolved value against the operands it came with.
  logic is_member, none_above, none_below;
  always_comb begin
    is_member  = 1'b0;
    none_above = 1'b1;
    none_below = 1'b1;
    for (int i = 0; i < N_OPS; i++) begin
      if (ops_s[WIDTH][i*WIDTH +: WIDTH] == res_s[WIDTH]) is_member  = 1'b1;
      if (ops_s[WIDTH][i*WIDTH +: WIDTH] >  res_s[WIDTH]) none_above = 1'b0;
      if (ops_s[WIDTH][i*WIDTH +: WIDTH] <  res_s[WIDTH]) none_below = 1'b0;
    end
  end

  a_r5_member: assert property (@(posedge clk) disable iff (rst)
    vld_s[WIDTH] |-> is_member);
  a_r1_upper_bound: assert property (@(posedge clk) disable iff (rst)
    (vld_s[WIDTH] && mode_s[WIDTH] == SEL_MAX) |-> none_above);
  a_r2_lower_bound: assert property (@(posedge clk) disable iff (rst)
    (vld_s[WIDTH] && mode_s[WIDTH] == SEL_MIN) |-> none_below);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !vld_s[WIDTH] |=> $stable(out_result));
endmodule

// File: tb/bitplane_minmax_bench.sv
module bitplane_minmax_bench;
  localparam int N  = 5;
  localparam int W  = 8;
  localparam int PE = 2;
  localparam int EV = (PE > 0) ? PE : 1;
  localparam int LAT = 1 + ((PE > 0) ? (W - 1) / EV : 0);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic sel_max = 1'b0;
  logic [N*W-1:0] operands = '0;
  logic out_valid;
  logic [W-1:0] out_result;

  bitplane_minmax #(.N_OPS(N), .WIDTH(W), .PIPE_EVERY(PE)) u_bitplane_minmax (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel_max(sel_max),
    .operands(operands), .out_valid(out_valid), .out_result(out_result)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] q_exp [$];
  int           q_due [$];
  string        q_tag [$];
  logic [W-1:0] last_res = '0;
  bit           mon_on = 1'b0;

  function automatic logic [W-1:0] ref_pick(input logic [N*W-1:0] v, input logic m);
    int best;
    best = v[0 +: W];
    for (int i = 1; i < N; i++) begin
      if (m  && int'(v[i*W +: W]) > best) best = v[i*W +: W];
      if (!m && int'(v[i*W +: W]) < best) best = v[i*W +: W];
    end
    return W'(best);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [N*W-1:0] v, input logic m, input string tag);
    @(negedge clk);
    operands = v;
    sel_max  = m;
    in_valid = 1'b1;
    q_exp.push_back(ref_pick(v, m));
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      operands = '1;
    end
  endtask

  // Output monitor: timing (R7), value, and holding between strobes (R8).
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", 1, 0);
        end else begin
          check(q_due[0] == cyc, "R7 latency", cyc, q_due[0]);
          check(out_result == q_exp[0], q_tag[0], out_result, q_exp[0]);
          void'(q_exp.pop_front());
          void'(q_due.pop_front());
          void'(q_tag.pop_front());
        end
        last_res = out_result;
      end else begin
        check(out_result == last_res, "R8 hold", out_result, last_res);
        if (q_due.size() > 0 && q_due[0] <= cyc)
          check(1'b0, "R7 missing strobe", 0, 1);
      end
    end
  end

  initial begin
    logic [N*W-1:0] v;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
    check(out_result == '0, "R9 result in reset", out_result, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
    check(out_result == '0, "R9 result after reset", out_result, 0);
    mon_on = 1'b1;

    // R3: the worked example, both modes back to back
    v = {8'd48, 8'd179, 8'd59, 8'd237, 8'd25};
    send(v, 1'b1, "R3 example max");
    send(v, 1'b0, "R3 example min");
    idle(LAT + 2);
    check(last_res == 8'd25, "R3 last value", last_res, 25);

    // R4/R6: every all-equal vector, both modes
    for (int x = 0; x < (1 << W); x++) begin
      send({N{W'(x)}}, 1'b1, "R4 R6 all equal max");
      send({N{W'(x)}}, 1'b0, "R4 R6 all equal min");
    end
    send({N{W'(0)}}, 1'b1, "R6 zeros max");
    send({N{ONES}}, 1'b0, "R6 ones min");

    // R10: a single distinct value in each position
    for (int p = 0; p < N; p++) begin
      v = '0;
      v[p*W +: W] = 8'd200;
      send(v, 1'b1, "R10 lone high max");
      v = {N{ONES}};
      v[p*W +: W] = 8'd7;
      send(v, 1'b0, "R10 lone low min");
    end
    idle(3);

    // R4: dense ties from a tiny value range, with the mode alternating
    for (int k = 0; k < 3000; k++) begin
      v = '0;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom % 4) << ($urandom % 3);
      send(v, k[0], "R4 tie stream");
    end

    // R1/R2/R5/R7: wide random stream with random gaps and mode
    for (int k = 0; k < 6000; k++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      send(v, W'($urandom) > 127 ? 1'b1 : 1'b0, k[0] ? "R1 R5 random" : "R2 R5 random");
      if (($urandom % 7) == 0) idle(1 + $urandom % 3);
    end

    // R1/R2: values sharing the high bits and differing only low
    for (int a = 0; a < 256; a += 3) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(a) ^ W'(i);
      send(v, 1'b1, "R1 near values");
      send(v, 1'b0, "R2 near values");
    end

    idle(LAT + 3);
    check(q_exp.size() == 0, "R7 drained", q_exp.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule